// File: doc/BRIEF.md
# Transmit Buffer Priority Arbiter

This block decides which of several local transmit message buffers is sent next on a CAN-style serial bus. Every buffer has an 8-bit local priority value and an empty flag. A buffer whose empty flag is clear holds a queued message and competes for the next frame. When the framing logic pulses `sof_req` just before a start of frame, the arbiter compares the priority values of all competing buffers. The numerically smallest value wins, and a tie goes to the lower buffer index. The result is registered as an index, a valid bit and a one-hot grant.

Software reaches a buffer's priority value through a buffer select index. That access is allowed only while the selected buffer is empty, so a priority cannot change under a queued message. Software queues a message by clearing the buffer's empty flag. The framing logic retires the granted buffer with a `done` pulse. That pulse sets the buffer's empty flag again and drops the grant.

Top module: `tx_prio_arbiter`

## Requirements
- R1: After reset, every empty flag reads 1 and every priority value is 0. `grant_valid` is 0, `grant` is all zeros and `grant_idx` is 0.
- R2: Among competing buffers, the one with the numerically smallest priority value is granted.
- R3: If several competing buffers share the smallest priority value, the one with the lowest index is granted.
- R4: Only buffers whose empty flag is 0 compete. While `grant_valid` is 1, the empty flag of the buffer at `grant_idx` is 0.
- R5: The outputs `grant_idx`, `grant_valid` and `grant` change on the clock edge after the cycle in which `sof_req` is high. They reflect the flags and priorities of that cycle and keep their value until the next `sof_req` or `done`. When `grant_valid` is 1, `grant` has exactly bit `grant_idx` set.
- R6: If no buffer competes when `sof_req` is high, `grant_valid` becomes 0, `grant` becomes all zeros and `grant_idx` becomes 0.
- R7: `prio_we` writes `prio_wdata` into the buffer at `sel_idx` only if `sel_idx` is below the buffer count and that buffer's empty flag is 1. Any other write is ignored.
- R8: `prio_rdata` shows the selected buffer's priority value while `sel_idx` is in range and that buffer's empty flag is 1. Otherwise it shows 0. This output is combinational.
- R9: A `done` pulse while `grant_valid` is 1 sets the empty flag of the buffer at `grant_idx`. If `sof_req` is low in that cycle, it also clears `grant_valid`, `grant` and `grant_idx` on the next edge. A `done` pulse while `grant_valid` is 0 has no effect.
- R10: Bit i of `txe_clr` clears buffer i's empty flag on the next edge. If `done` retires the same buffer in the same cycle, the flag ends up set.
- R11: When `sof_req` and a valid `done` occur in the same cycle, the buffer being retired does not compete in that round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_idx | input | IW | Buffer selected for priority access |
| prio_we | input | 1 | Priority write strobe |
| prio_wdata | input | PW | Priority write data |
| prio_rdata | output | PW | Priority read data, 0 when access is not allowed |
| txe_clr | input | NBUF | Per-buffer request to clear the empty flag (queue a message) |
| sof_req | input | 1 | Start-of-frame arbitration strobe |
| done | input | 1 | Granted buffer has been sent |
| txe | output | NBUF | Empty flags, 1 means no pending message |
| grant_idx | output | IW | Winning buffer index |
| grant_valid | output | 1 | A buffer was granted |
| grant | output | NBUF | One-hot grant |

## Verification
A retire (`done`) and a new arbitration round (`sof_req`) can occur in the same cycle. In that case the buffer being retired must drop out of the round it would otherwise win again. The bench provokes this with a directed step in which two buffers are pending and the current winner is retired while `sof_req` is high, and the next buffer must be granted. Many more such cycles come from random stimulus. A behavioural model steps with the bench and judges every cycle, and it also covers a queue request and a retire landing on the same buffer.

// File: rtl/tx_prio_arbiter.sv
module tx_prio_arbiter #(
  parameter int NBUF = 3,
  parameter int PW   = 8,
  parameter int IW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   sel_idx,
  input  logic            prio_we,
  input  logic [PW-1:0]   prio_wdata,
  output logic [PW-1:0]   prio_rdata,
  input  logic [NBUF-1:0] txe_clr,
  input  logic            sof_req,
  input  logic            done,
  output logic [NBUF-1:0] txe,
  output logic [IW-1:0]   grant_idx,
  output logic            grant_valid,
  output logic [NBUF-1:0] grant
);

  logic [PW-1:0]      prio_q [NBUF];
  logic [NBUF-1:0]    txe_q, gnt_q;
  logic [IW-1:0]      gi_q;
  logic               gv_q;
  logic [NBUF*PW-1:0] prio_flat;

  wire sel_ok = int'(sel_idx) < NBUF;
  wire acc_ok = sel_ok ? txe_q[sel_idx] : 1'b0;
  wire retire = done && gv_q;
  wire [NBUF-1:0] retire_vec = retire ? gnt_q : '0;
  wire [NBUF-1:0] cand = ~txe_q & ~retire_vec;

  logic          win_found;
  logic [IW-1:0] win_idx;
  logic [PW-1:0] best;

  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    best      = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (cand[i] && (!win_found || prio_q[i] < best)) begin
        win_found = 1'b1;
        win_idx   = IW'(i);
        best      = prio_q[i];
      end
    end
  end

  wire [NBUF-1:0] win_vec = win_found ? (NBUF'(1) << win_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) prio_q[i] <= '0;
      txe_q <= '1;
      gv_q  <= 1'b0;
      gi_q  <= '0;
      gnt_q <= '0;
    end else begin
      if (prio_we && acc_ok) prio_q[sel_idx] <= prio_wdata;
      txe_q <= (txe_q & ~txe_clr) | retire_vec;
      if (sof_req) begin
        gv_q  <= win_found;
        gi_q  <= win_idx;
        gnt_q <= win_vec;
      end else if (retire) begin
        gv_q  <= 1'b0;
        gi_q  <= '0;
        gnt_q <= '0;
      end
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_flat
    assign prio_flat[g*PW +: PW] = prio_q[g];
  end

  assign prio_rdata  = acc_ok ? prio_q[sel_idx] : '0;
  assign txe         = txe_q;
  assign grant_idx   = gi_q;
  assign grant_valid = gv_q;
  assign grant       = gnt_q;

  p_grant_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gv_q |-> !txe_q[gi_q]);

  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gv_q |-> gnt_q == (NBUF'(1) << gi_q));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_req && !done) |=> ($stable(gnt_q) && $stable(gv_q) && $stable(gi_q)));

  p_no_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gv_q |-> (gnt_q == '0));

  p_prio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(prio_we && acc_ok) |=> $stable(prio_flat));

  p_retire_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && gv_q) |=> txe_q[$past(gi_q)]);

  p_retire_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && gv_q && !sof_req) |=> !gv_q);

  p_retire_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && gv_q && sof_req) |=> !(gv_q && gi_q == $past(gi_q)));

endmodule

// File: tb/test_tx_prio_arbiter.sv
module test_tx_prio_arbiter;
  localparam int NB = 3;
  localparam int PW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] sel_idx = '0;
  logic          prio_we = 1'b0;
  logic [PW-1:0] prio_wdata = '0;
  logic [PW-1:0] prio_rdata;
  logic [NB-1:0] txe_clr = '0;
  logic          sof_req = 1'b0;
  logic          done = 1'b0;
  logic [NB-1:0] txe;
  logic [IW-1:0] grant_idx;
  logic          grant_valid;
  logic [NB-1:0] grant;

  tx_prio_arbiter #(.NBUF(NB), .PW(PW)) i_tx_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .prio_we(prio_we),
    .prio_wdata(prio_wdata), .prio_rdata(prio_rdata), .txe_clr(txe_clr),
    .sof_req(sof_req), .done(done), .txe(txe), .grant_idx(grant_idx),
    .grant_valid(grant_valid), .grant(grant));

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int m_txe [NB];
  int m_prio [NB];
  int m_gv = 0, m_gi = 0;
  string gtag = "R5";

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    for (int i = 0; i < NB; i++) chk("R10", "txe", int'(txe[i]), m_txe[i]);
    chk(gtag, "grant_valid", int'(grant_valid), m_gv);
    chk(gtag, "grant_idx", int'(grant_idx), m_gi);
    chk(gtag, "grant", int'(grant), m_gv ? (1 << m_gi) : 0);
  endtask

  task automatic cyc(int sel, bit we, int wd, int clr, bit sof, bit dn);
    int n_txe [NB];
    int n_prio [NB];
    int n_gv, n_gi, best, found;
    bit retire;
    sel_idx = IW'(sel); prio_we = we; prio_wdata = PW'(wd);
    txe_clr = NB'(clr); sof_req = sof; done = dn;
    #1;
    chk("R8", "prio_rdata", int'(prio_rdata),
        (sel < NB && m_txe[sel] == 1) ? m_prio[sel] : 0);
    retire = dn && m_gv == 1;
    n_txe = m_txe; n_prio = m_prio; n_gv = m_gv; n_gi = m_gi;
    if (we && sel < NB && m_txe[sel] == 1) n_prio[sel] = wd;
    for (int i = 0; i < NB; i++) if (clr[i]) n_txe[i] = 0;
    if (retire) n_txe[m_gi] = 1;
    if (sof) begin
      found = 0; best = 0; n_gi = 0;
      for (int i = 0; i < NB; i++) begin
        if (m_txe[i] == 0 && !(retire && i == m_gi))
          if (!found || m_prio[i] < best) begin found = 1; best = m_prio[i]; n_gi = i; end
      end
      n_gv = found;
    end else if (retire) begin
      n_gv = 0; n_gi = 0;
    end
    @(posedge clk);
    m_txe = n_txe; m_prio = n_prio; m_gv = n_gv; m_gi = n_gi;
    @(negedge clk);
    check_regs();
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask

  initial begin
    for (int i = 0; i < NB; i++) begin m_txe[i] = 1; m_prio[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, every priority reads 0
    gtag = "R1";
    check_regs();
    for (int i = 0; i < NB; i++) cyc(i, 0, 0, 0, 0, 0);
    // R7/R8: writes while empty, read back; out-of-range select ignored
    gtag = "R5";
    cyc(0, 1, 5, 0, 0, 0);
    cyc(1, 1, 5, 0, 0, 0);
    cyc(2, 1, 9, 0, 0, 0);
    cyc(3, 1, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(i, 0, 0, 0, 0, 0);
    // R10: queue all three
    cyc(0, 0, 0, 7, 0, 0);
    // R7: write to pending buffer ignored; R8: reads 0
    cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    // R3: tie 5/5 -> index 0
    gtag = "R3"; cyc(0, 0, 0, 0, 1, 0);
    gtag = "R5"; idle(); idle();
    // R9: retire buffer 0
    gtag = "R9"; cyc(0, 0, 0, 0, 0, 1);
    // R2: 5 beats 9
    gtag = "R2"; cyc(0, 0, 0, 0, 1, 0);
    // R11: retire 1 and arbitrate in same cycle -> 2
    gtag = "R11"; cyc(0, 0, 0, 0, 1, 1);
    // R9: retire 2, then R6: nothing pending
    gtag = "R9"; cyc(0, 0, 0, 0, 0, 1);
    gtag = "R6"; cyc(0, 0, 0, 0, 1, 0);
    // R9: done without grant has no effect
    gtag = "R9"; cyc(0, 0, 0, 0, 0, 1);
    // R4: only buffer 2 pending though it has the largest value
    gtag = "R4"; cyc(0, 0, 0, 4, 0, 0); cyc(0, 0, 0, 0, 1, 0);
    // R10: clear and retire same buffer -> stays empty
    gtag = "R10"; cyc(0, 0, 0, 4, 0, 1);
    // random mix
    gtag = "R5";
    for (int n = 0; n < 4000; n++)
      cyc($urandom_range(3), ($urandom_range(9) < 3), $urandom_range(255),
          ($urandom_range(9) == 0) ? $urandom_range(7) : 0,
          ($urandom_range(4) == 0), ($urandom_range(4) == 0));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule